// File: doc/BRIEF.md
# MMC/SD Command and Response Sequencer

This block sits on the host side of an MMC/SD controller. It holds the command index, a 32-bit argument and a small command-control word. When the controller is told to run a command and the card clock is on, the block issues one command request to a card-side agent over a valid/ready handshake. It then collects the response bytes that the agent streams back.

When the agent marks the end of the response, the block checks the byte count against the response type that was selected. A response that is long enough raises the end-of-response status and an end-of-command interrupt request. If the command has a data phase, the block also arms it by loading a byte count equal to block length times block count. A response that is too short sets the response-timeout status instead, and the data phase is skipped.

The received bytes are packed into nine 16-bit words. Software reads them through a read-once port. If the command is written while the clock is off, it is held pending and fires when the clock is started.

Top module: `sd_cmdseq`

## Requirements
- R1: `idx_rd` returns the stored 6-bit command index in bits 5:0, with bit 6 set and bit 7 clear. Writes to the index (select code 0) keep only the low 6 bits of the data.
- R2: The argument is written as two halves. Select code 1 writes bits 31:16 and select code 2 writes bits 15:0. Each write leaves the other half unchanged, and `arg_rd` shows the full value.
- R3: A response length is good when it meets the minimum for its type. The type is control-word bits 1:0. Type 0 needs 0 bytes, types 1 and 3 need at least 4 bytes, and type 2 needs at least 16 bytes. The length is the number of bytes accepted up to and including the cycle that carries `rsp_end`.
- R4: A good response sets `st_resp_end` and `irq_end_cmd` in the cycle after `rsp_end`. A short response sets only `st_resp_tout`, and it raises neither the interrupt request nor the data arm.
- R5: A control write (select code 3) with bit 10 clear launches the command at once if the clock is on. If the clock is off, `st_pending` is set instead, and the command launches on the next `clk_start` pulse. A control write with bit 10 set launches nothing and clears the pending flag.
- R6: Received bytes are packed two per word, with the earlier byte in bits 15:8. Only the first 18 bytes are kept. `res_word` shows the current word. Each `res_pop` moves to the next word. After nine pops, `res_word` reads zero and stays at zero.
- R7: A good response with control bit 2 set gives a one-cycle `data_go` pulse. It also loads `data_bytes` with the block length times the block count. The block length is the low 12 bits of a select-code-4 write, and the block count is the low 16 bits of a select-code-5 write.
- R8: A launch clears both status bits, the interrupt request, the stored response and the read index. In the cycle after the launch, it gives a one-cycle `fifo_flush` pulse.
- R9: `req_valid` stays high until `req_ready` is seen, and `req_idx` and `req_arg` stay stable while it is high. `rsp_ready` is high only in the response phase, after the request has been accepted.
- R10: Control writes made while a command is in progress (`st_busy`) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 index, 1 argument high, 2 argument low, 3 control, 4 block length, 5 block count |
| cfg_wdata | input | 16 | Register write data |
| clk_start | input | 1 | Pulse that turns the card clock on |
| clk_stop | input | 1 | Pulse that turns the card clock off |
| idx_rd | output | 8 | Command index read-back, with bit 6 set |
| arg_rd | output | 32 | Argument read-back |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Card agent accepts the request |
| req_idx | output | 6 | Index of the command being requested |
| req_arg | output | 32 | Argument of the command being requested |
| rsp_valid | input | 1 | Response byte valid |
| rsp_ready | output | 1 | Block accepts response bytes |
| rsp_data | input | 8 | Response byte |
| rsp_end | input | 1 | Marks the end of the response; may come with or without a byte |
| res_pop | input | 1 | Advance the response read port |
| res_word | output | 16 | Current response word |
| st_clk_on | output | 1 | Card clock is on |
| st_pending | output | 1 | A command is waiting for the clock |
| st_busy | output | 1 | A command is in progress |
| st_resp_end | output | 1 | A good response was received |
| st_resp_tout | output | 1 | The response was too short |
| irq_end_cmd | output | 1 | End-of-command interrupt request |
| fifo_flush | output | 1 | One-cycle pulse that clears the data FIFOs |
| data_go | output | 1 | One-cycle pulse that arms the data phase |
| data_bytes | output | 28 | Byte count for the data phase |

## Verification
The assertions assume that the card agent behaves well. It asserts `rsp_valid` and `rsp_end` only while `rsp_ready` is high, and it raises `req_ready` only while `req_valid` is high. They also assume that `res_pop` is used only while the block is idle, and that `clk_start` never lands in the same cycle as a control write. The bench drives the card side from tasks that wait for the matching phase before they drive anything. It pops responses only after the end pulse, and it keeps clock pulses and register writes in separate cycles.

// File: rtl/sd_cmdseq_pkg.sv
package sd_cmdseq_pkg;
  typedef enum logic [2:0] {
    SEL_INDEX  = 3'd0,
    SEL_ARG_HI = 3'd1,
    SEL_ARG_LO = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_BLKLEN = 3'd4,
    SEL_BLKCNT = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_RESP = 2'd2
  } phase_e;

  localparam int CTRL_DEN_BIT  = 2;
  localparam int CTRL_STOP_BIT = 10;
endpackage

// File: rtl/sd_rsp_len_check.sv
module sd_rsp_len_check #(
  parameter int CB          = 5,
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16
) (
  input  logic [1:0]    rtype,
  input  logic [CB-1:0] nbytes,
  output logic          ok
);
  logic [CB-1:0] need;

  always_comb begin
    case (rtype)
      2'd0:    need = '0;
      2'd2:    need = CB'(LONG_BYTES);
      default: need = CB'(SHORT_BYTES);
    endcase
  end

  assign ok = (nbytes >= need);
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store #(
  parameter int WORDS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  input  logic        pop,
  output logic [15:0] rd_word
);
  localparam int BYTES = 2 * WORDS;
  localparam int PW    = $clog2(BYTES + 1);
  localparam int RW    = $clog2(WORDS + 1);

  logic [7:0]    mem [BYTES];
  logic [PW-1:0] wptr;
  logic [RW-1:0] ridx;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        mem[b] <= '0;
      else if (wr_en && wptr == PW'(b))
        mem[b] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      ridx <= '0;
    end else begin
      if (wr_en && wptr < PW'(BYTES))
        wptr <= wptr + 1'b1;
      if (pop && ridx < RW'(WORDS))
        ridx <= ridx + 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++)
      if (ridx == RW'(w))
        rd_word = {mem[2*w], mem[2*w+1]};
  end
endmodule

// File: rtl/sd_cmdseq.sv
module sd_cmdseq
  import sd_cmdseq_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int ARG_W       = 32,
  parameter int BLKLEN_W    = 12,
  parameter int BLKCNT_W    = 16,
  parameter int RSP_WORDS   = 9,
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16,
  localparam int HALF_W     = ARG_W / 2,
  localparam int CNT_W      = BLKLEN_W + BLKCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [HALF_W-1:0] cfg_wdata,
  input  logic              clk_start,
  input  logic              clk_stop,
  output logic [IDX_W+1:0]  idx_rd,
  output logic [ARG_W-1:0]  arg_rd,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_idx,
  output logic [ARG_W-1:0]  req_arg,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_end,
  input  logic              res_pop,
  output logic [15:0]       res_word,
  output logic              st_clk_on,
  output logic              st_pending,
  output logic              st_busy,
  output logic              st_resp_end,
  output logic              st_resp_tout,
  output logic              irq_end_cmd,
  output logic              fifo_flush,
  output logic              data_go,
  output logic [CNT_W-1:0]  data_bytes
);
  localparam int RSP_BYTES = 2 * RSP_WORDS;
  localparam int CB        = $clog2(RSP_BYTES + 2);

  phase_e               phase;
  reg_sel_e             sel;
  logic [IDX_W-1:0]     idx_q;
  logic [ARG_W-1:0]     arg_q;
  logic [1:0]           rtype_q;
  logic                 den_q;
  logic                 stop_q;
  logic [BLKLEN_W-1:0]  blklen_q;
  logic [BLKCNT_W-1:0]  blkcnt_q;
  logic [CB-1:0]        rcv_cnt;
  logic [CB-1:0]        cnt_eff;
  logic                 idle;
  logic                 ctrl_wr;
  logic                 clk_eff;
  logic                 launch;
  logic                 len_ok;
  logic                 accept;

  assign sel     = reg_sel_e'(cfg_sel);
  assign idle    = (phase == PH_IDLE);
  assign ctrl_wr = cfg_we && sel == SEL_CTRL && idle;
  assign clk_eff = (st_clk_on || clk_start) && !clk_stop;
  assign launch  = idle && ((ctrl_wr && !cfg_wdata[CTRL_STOP_BIT] && clk_eff) ||
                            (!ctrl_wr && st_pending && !stop_q && clk_start && !clk_stop));
  assign accept  = (phase == PH_RESP) && rsp_valid;
  assign cnt_eff = (accept && rcv_cnt != '1) ? rcv_cnt + 1'b1 : rcv_cnt;

  assign idx_rd    = {1'b0, 1'b1, idx_q};
  assign arg_rd    = arg_q;
  assign req_valid = (phase == PH_REQ);
  assign rsp_ready = (phase == PH_RESP);
  assign st_busy   = !idle;

  sd_rsp_len_check #(
    .CB(CB), .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES)
  ) u_len (
    .rtype (rtype_q),
    .nbytes(cnt_eff),
    .ok    (len_ok)
  );

  sd_rsp_store #(.WORDS(RSP_WORDS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (launch),
    .wr_en  (accept),
    .wr_byte(rsp_data),
    .pop    (res_pop),
    .rd_word(res_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx_q <= '0;
      arg_q <= '0;
      rtype_q <= '0;
      den_q <= 1'b0;
      stop_q <= 1'b0;
      blklen_q <= '0;
      blkcnt_q <= '0;
      rcv_cnt <= '0;
      req_idx <= '0;
      req_arg <= '0;
      st_clk_on <= 1'b0;
      st_pending <= 1'b0;
      st_resp_end <= 1'b0;
      st_resp_tout <= 1'b0;
      irq_end_cmd <= 1'b0;
      fifo_flush <= 1'b0;
      data_go <= 1'b0;
      data_bytes <= '0;
    end else begin
      fifo_flush <= 1'b0;
      data_go <= 1'b0;

      if (cfg_we) begin
        case (sel)
          SEL_INDEX:  idx_q <= cfg_wdata[IDX_W-1:0];
          SEL_ARG_HI: arg_q[ARG_W-1:HALF_W] <= cfg_wdata;
          SEL_ARG_LO: arg_q[HALF_W-1:0] <= cfg_wdata;
          SEL_BLKLEN: blklen_q <= cfg_wdata[BLKLEN_W-1:0];
          SEL_BLKCNT: blkcnt_q <= cfg_wdata[BLKCNT_W-1:0];
          SEL_CTRL: if (idle) begin
            rtype_q <= cfg_wdata[1:0];
            den_q <= cfg_wdata[CTRL_DEN_BIT];
            stop_q <= cfg_wdata[CTRL_STOP_BIT];
          end
          default: ;
        endcase
      end

      if (clk_start) st_clk_on <= 1'b1;
      if (clk_stop)  st_clk_on <= 1'b0;

      if (launch)
        st_pending <= 1'b0;
      else if (ctrl_wr)
        st_pending <= !cfg_wdata[CTRL_STOP_BIT];

      case (phase)
        PH_IDLE: if (launch) begin
          phase <= PH_REQ;
          req_idx <= idx_q;
          req_arg <= arg_q;
          st_resp_end <= 1'b0;
          st_resp_tout <= 1'b0;
          irq_end_cmd <= 1'b0;
          fifo_flush <= 1'b1;
          rcv_cnt <= '0;
        end
        PH_REQ: if (req_ready) phase <= PH_RESP;
        PH_RESP: begin
          rcv_cnt <= cnt_eff;
          if (rsp_end) begin
            phase <= PH_IDLE;
            if (len_ok) begin
              st_resp_end <= 1'b1;
              irq_end_cmd <= 1'b1;
              if (den_q) begin
                data_go <= 1'b1;
                data_bytes <= CNT_W'(blklen_q) * CNT_W'(blkcnt_q);
              end
            end else begin
              st_resp_tout <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmdseq_chk.sv
module sd_cmdseq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic [5:0] req_idx,
  input logic [31:0] req_arg,
  input logic rsp_ready,
  input logic st_pending,
  input logic st_busy,
  input logic st_resp_end,
  input logic st_resp_tout,
  input logic irq_end_cmd,
  input logic fifo_flush,
  input logic data_go
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_idx) && $stable(req_arg)));

  assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_status_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_resp_end && st_resp_tout));

  assert_tout_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_resp_tout |-> !irq_end_cmd);

  assert_arm_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |-> (st_resp_end && !st_busy));

  assert_flush_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (!st_resp_end && !st_resp_tout && !irq_end_cmd && req_valid));

  assert_pending_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_pending && st_busy));

  assert_flush_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush);
endmodule

bind sd_cmdseq sd_cmdseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_idx(req_idx), .req_arg(req_arg), .rsp_ready(rsp_ready),
  .st_pending(st_pending), .st_busy(st_busy), .st_resp_end(st_resp_end),
  .st_resp_tout(st_resp_tout), .irq_end_cmd(irq_end_cmd),
  .fifo_flush(fifo_flush), .data_go(data_go)
);

// File: tb/sd_cmdseq_test.sv
`timescale 1ns/1ps
module sd_cmdseq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic clk_start = 1'b0, clk_stop = 1'b0;
  logic [7:0] idx_rd;
  logic [31:0] arg_rd;
  logic req_valid, req_ready = 1'b0;
  logic [5:0] req_idx;
  logic [31:0] req_arg;
  logic rsp_valid = 1'b0, rsp_ready, rsp_end = 1'b0;
  logic [7:0] rsp_data = '0;
  logic res_pop = 1'b0;
  logic [15:0] res_word;
  logic st_clk_on, st_pending, st_busy, st_resp_end, st_resp_tout, irq_end_cmd;
  logic fifo_flush, data_go;
  logic [27:0] data_bytes;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_cmdseq uut (.*);

  // Vector fields: [9:8] type, [7] data enable, [6:2] byte count, [1] exp timeout, [0] exp good
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 1'b0, 5'd0,  1'b0, 1'b1},
    {2'd1, 1'b1, 5'd4,  1'b0, 1'b1},
    {2'd1, 1'b1, 5'd3,  1'b1, 1'b0},
    {2'd2, 1'b0, 5'd16, 1'b0, 1'b1},
    {2'd2, 1'b0, 5'd15, 1'b1, 1'b0},
    {2'd3, 1'b0, 5'd6,  1'b0, 1'b1},
    {2'd3, 1'b0, 5'd0,  1'b1, 1'b0},
    {2'd2, 1'b1, 5'd18, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    clk_start = 1'b1; @(negedge clk); clk_start = 1'b0;
  endtask

  task automatic pulse_stop();
    clk_stop = 1'b1; @(negedge clk); clk_stop = 1'b0;
  endtask

  task automatic grant();
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic feed(int n);
    if (n == 0) begin
      rsp_end = 1'b1; @(negedge clk); rsp_end = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        rsp_valid = 1'b1; rsp_data = 8'h10 + 8'(i); rsp_end = (i == n - 1);
        @(negedge clk);
      end
      rsp_valid = 1'b0; rsp_end = 1'b0;
    end
  endtask

  function automatic logic [7:0] exp_byte(int k, int n);
    return (k < n && k < 18) ? 8'h10 + 8'(k) : 8'h00;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("reset R1 idx", 32'(idx_rd), 32'h40);
    chk("reset R2 arg", arg_rd, 0);
    chk("reset R9 req_valid", 32'(req_valid), 0);
    chk("reset R9 rsp_ready", 32'(rsp_ready), 0);
    chk("reset R4 status", {28'd0, st_resp_end, st_resp_tout, irq_end_cmd, st_clk_on}, 0);
    chk("reset R6 res_word", 32'(res_word), 0);

    // R1
    wr(3'd0, 16'h00FF);
    chk("R1 index masked", 32'(idx_rd), 32'h7F);
    wr(3'd0, 16'h0005);
    chk("R1 index", 32'(idx_rd), 32'h45);
    // R2
    wr(3'd1, 16'hABCD);
    wr(3'd2, 16'h1234);
    chk("R2 both halves", arg_rd, 32'hABCD1234);
    wr(3'd2, 16'h5678);
    chk("R2 low only", arg_rd, 32'hABCD5678);
    wr(3'd1, 16'h0F0F);
    chk("R2 high only", arg_rd, 32'h0F0F5678);

    // R7 block geometry
    wr(3'd4, 16'hF003);
    wr(3'd5, 16'h0005);

    // R5 pending with clock off
    wr(3'd3, 16'h0001);
    chk("R5 pending", 32'(st_pending), 1);
    @(negedge clk);
    chk("R5 no launch while clock off", 32'(req_valid), 0);
    pulse_start();
    chk("R5 launch on clock start", 32'(req_valid), 1);
    chk("R8 flush pulse", 32'(fifo_flush), 1);
    chk("R9 req_idx", 32'(req_idx), 32'h05);
    chk("R9 req_arg", req_arg, 32'h0F0F5678);
    // R9 hold while not ready; R10 ctrl write ignored while busy
    wr(3'd2, 16'h9999);
    wr(3'd3, 16'h0002);
    chk("R9 req held", 32'(req_valid), 1);
    chk("R9 req_arg stable", req_arg, 32'h0F0F5678);
    chk("R9 rsp_ready low in request", 32'(rsp_ready), 0);
    grant();
    chk("R9 rsp_ready in response", 32'(rsp_ready), 1);
    feed(4);
    chk("R10 busy ctrl write ignored", 32'(st_resp_end), 1);
    chk("R4 irq", 32'(irq_end_cmd), 1);

    // R5 stop bit: no launch
    wr(3'd3, 16'h0401);
    @(negedge clk);
    chk("R5 stop bit no launch", 32'(req_valid), 0);
    chk("R5 stop bit no pending", 32'(st_pending), 0);

    // table of vectors
    for (int v = 0; v < 8; v++) begin
      logic [1:0] t;
      logic den;
      int n;
      logic goseen;
      t = VEC[v][9:8];
      den = VEC[v][7];
      n = int'(VEC[v][6:2]);
      wr(3'd3, {13'd0, den, t});
      chk("R8 status cleared at launch", {29'd0, st_resp_end, st_resp_tout, irq_end_cmd}, 0);
      chk("R8 response cleared", 32'(res_word), 0);
      grant();
      feed(n);
      goseen = data_go;
      chk("R3 timeout by length", 32'(st_resp_tout), 32'(VEC[v][1]));
      chk("R3 good by length", 32'(st_resp_end), 32'(VEC[v][0]));
      chk("R4 irq on good only", 32'(irq_end_cmd), 32'(VEC[v][0]));
      chk("R7 data arm", 32'(goseen), 32'(den & VEC[v][0]));
      if (den && VEC[v][0]) chk("R7 byte count", 32'(data_bytes), 15);
      @(negedge clk);
      chk("R7 arm is one cycle", 32'(data_go), 0);
      for (int w = 0; w < 10; w++) begin
        chk("R6 response word", 32'(res_word),
            {16'd0, exp_byte(2 * w, n), exp_byte(2 * w + 1, n)});
        res_pop = 1'b1; @(negedge clk); res_pop = 1'b0;
      end
      chk("R6 stays zero", 32'(res_word), 0);
    end

    // R8 read index resets at next command, R6 read-once
    wr(3'd3, 16'h0001);
    grant();
    feed(5);
    res_pop = 1'b1; @(negedge clk); res_pop = 1'b0;
    chk("R6 second word", 32'(res_word), 32'h1213);
    pulse_stop();
    chk("R5 clock off", 32'(st_clk_on), 0);
    wr(3'd3, 16'h0000);
    chk("R8 old response kept until launch", 32'(res_word), 32'h1213);
    pulse_start();
    chk("R8 index reset and cleared", 32'(res_word), 0);
    grant();
    feed(0);
    chk("R3 type 0 no bytes good", 32'(st_resp_end), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule